// File: doc/BRIEF.md
# Double-Buffered Pedestal Table Controller

This block holds two pedestal tables. The live data path reads one of them, the active table, while the other, the shadow table, is rewritten at leisure through a slow configuration port. When the configuration side has finished a full rewrite, it raises an update-done strobe. The controller then waits for the next frame-start pulse and swaps the two roles on that clock edge. A frame therefore always reads a single, complete table and never a table that is only partly written.

Each stored word is a single-error-correcting, double-error-detecting Hamming codeword. The configuration port encodes each word on its way in. The read path checks and corrects each word on its way out, and has a fixed, parameterised latency. A flip mask on the write port lets a caller store a deliberately damaged codeword, so the correction path can be exercised. Single-bit corrections are counted in a saturating counter. A double-bit error raises a per-read flag and a sticky status flag. The subtraction arithmetic and the raw-frame storage are handled outside this block.

Top module: `ped_dbuf_ctrl`

## Requirements
- R1: After reset, table 0 is active, no swap is pending, rd_valid, rd_dbe, cfg_reject and dbe_seen are low, and sbe_count is zero.
- R2: A configuration write whose cfg_wr_bank names the shadow table is stored at cfg_addr, and cfg_reject stays low in the following cycle.
- R3: A configuration write whose cfg_wr_bank names the active table leaves both tables unchanged, and cfg_reject is high for exactly the cycle after that write.
- R4: An upd_done pulse sets swap_pending on the next edge. active_bank does not change until a frame_start is sampled.
- R5: When frame_start is sampled while swap_pending is high, active_bank toggles and swap_pending clears on that edge. A frame_start without a pending swap changes nothing. An upd_done sampled on the same edge as a frame_start with no swap pending sets swap_pending, and the swap waits for the next frame_start.
- R6: rd_en may be high on every cycle. For a read sampled at edge e, rd_valid and rd_data, holding the word at rd_addr of the active table, appear after edge e+RD_LAT.
- R7: The table read is the one that is active when rd_en is sampled. A read sampled on the same edge as a swap returns the old table.
- R8: Bit i of cfg_flip inverts bit i of the stored codeword. A word stored with exactly one bit inverted (any bit, including the overall parity bit) reads back with the original data, and sbe_count rises by one on the edge that raises rd_valid, saturating at its all-ones value.
- R9: A word stored with exactly two bits inverted reads back with rd_dbe high alongside rd_valid. dbe_seen then stays high until reset.
- R10: A word written with an all-zero cfg_flip reads back unchanged, with rd_dbe low and sbe_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse; a pending swap takes effect here |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_bank | input | 1 | Target table of the write (0 or 1) |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | DATA_W | Pedestal value to store |
| cfg_flip | input | CW | Mask XORed into the encoded codeword before storage |
| upd_done | input | 1 | Background rewrite finished; request a swap |
| cfg_reject | output | 1 | The previous write targeted the active table and was dropped |
| rd_en | input | 1 | Data-path read request |
| rd_addr | input | AW | Data-path read address |
| rd_valid | output | 1 | rd_data carries a read result |
| rd_data | output | DATA_W | Corrected pedestal value |
| rd_dbe | output | 1 | The current result had an uncorrectable error |
| active_bank | output | 1 | Index of the table the data path reads |
| swap_pending | output | 1 | A swap waits for the next frame_start |
| sbe_count | output | CNT_W | Saturating count of corrected single-bit errors |
| dbe_seen | output | 1 | Sticky flag: an uncorrectable error was read |

## Verification
A wrong active-table index shows up in the first read after the faulty edge. That read returns the other table's data RD_LAT edges later, and active_bank itself is visible at once. A stuck or wrongly cleared swap request shows on swap_pending one edge after upd_done or frame_start. A misplaced data or parity bit in the code shows only through stored words with inverted bits: it appears as a wrong corrected value, a missing count step or a false rd_dbe on that read. A pipeline length error shows as a result one edge early or late relative to its request.

// File: rtl/ped_pkg.sv
package ped_pkg;

   // Number of Hamming check bits (excluding the overall parity bit) for dw data bits
   function automatic int unsigned hm_par_bits(input int unsigned dw);
      int unsigned p;
      p = 1;
      while ((1 << p) < (dw + p + 1)) p++;
      return p;
   endfunction

   // Positions (1..cw-1) whose index has bit j set: the coverage of check bit j
   function automatic logic [255:0] hm_cover(input int unsigned j, input int unsigned cw);
      logic [255:0] m;
      m = '0;
      for (int unsigned p = 1; p < cw; p++) begin
         if (((p >> j) & 1) != 0) m = m | (256'(1) << p);
      end
      return m;
   endfunction

endpackage

// File: rtl/ped_secded_enc.sv
module ped_secded_enc #(
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned PAR_W  = ped_pkg::hm_par_bits(DATA_W),
   localparam int unsigned CW     = DATA_W + PAR_W + 1
) (
   input  logic [DATA_W-1:0] din,
   output logic [CW-1:0]     code
);

   logic [CW-1:0] spread;
   logic [CW-1:1] ham;

   assign spread[0] = 1'b0;

   for (genvar pos = 1; pos < CW; pos++) begin : g_pos
      if ((pos & (pos - 1)) != 0) begin : g_data
         assign spread[pos] = din[pos - 1 - $clog2(pos + 1)];
         assign ham[pos]    = spread[pos];
      end else begin : g_chk
         localparam logic [255:0] CMF = ped_pkg::hm_cover($clog2(pos), CW);
         assign spread[pos] = 1'b0;
         assign ham[pos]    = ^(spread & CMF[CW-1:0]);
      end
   end

   assign code = {ham, ^ham};

endmodule

// File: rtl/ped_secded_dec.sv
module ped_secded_dec #(
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned PAR_W  = ped_pkg::hm_par_bits(DATA_W),
   localparam int unsigned CW     = DATA_W + PAR_W + 1
) (
   input  logic [CW-1:0]     code,
   output logic [DATA_W-1:0] dout,
   output logic              fixed,
   output logic              fatal
);

   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic [PAR_W-1:0] syn;
   logic             overall;
   logic [CW-1:0]    flip;
   logic [CW-1:0]    corr;

   for (genvar j = 0; j < PAR_W; j++) begin : g_syn
      localparam logic [255:0] CMF = ped_pkg::hm_cover(j, CW);
      assign syn[j] = ^(code & CMF[CW-1:0]);
   end

   assign overall = ^code;

   always_comb begin
      fixed = 1'b0;
      fatal = 1'b0;
      flip  = '0;
      if (overall) begin
         if (32'(syn) < CW) begin
            fixed = 1'b1;
            flip  = ONE << syn;
         end else begin
            fatal = 1'b1;
         end
      end else if (syn != '0) begin
         fatal = 1'b1;
      end
   end

   assign corr = code ^ flip;

   for (genvar pos = 1; pos < CW; pos++) begin : g_pos
      if ((pos & (pos - 1)) != 0) begin : g_data
         assign dout[pos - 1 - $clog2(pos + 1)] = corr[pos];
      end
   end

endmodule

// File: rtl/ped_bank.sv
module ped_bank #(
   parameter  int unsigned DEPTH = 64,
   parameter  int unsigned CW    = 39,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [CW-1:0] wcode,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [CW-1:0] rcode
);

   logic [CW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wcode;
      if (re) rcode <= mem[raddr];
   end

endmodule

// File: rtl/ped_swap_ctrl.sv
module ped_swap_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic upd_done,
   output logic active,
   output logic pending
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         pending <= 1'b0;
      end else if (frame_start && pending) begin
         active  <= ~active;
         pending <= 1'b0;
      end else if (upd_done) begin
         pending <= 1'b1;
      end
   end

   // R5
   active_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active != $past(active)) |-> $past(frame_start && pending));

   // R4
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !frame_start) |=> pending);

endmodule

// File: rtl/ped_dbuf_ctrl.sv
module ped_dbuf_ctrl #(
   parameter  int unsigned DATA_W = 32,
   parameter  int unsigned DEPTH  = 64,
   parameter  int unsigned RD_LAT = 2,
   parameter  int unsigned CNT_W  = 8,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = DATA_W + ped_pkg::hm_par_bits(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_bank,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [CW-1:0]     cfg_flip,
   input  logic              upd_done,
   output logic              cfg_reject,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_dbe,
   output logic              active_bank,
   output logic              swap_pending,
   output logic [CNT_W-1:0]  sbe_count,
   output logic              dbe_seen
);

   localparam int unsigned STG = RD_LAT;

   if (RD_LAT < 2) begin : g_bad_lat
      $error("RD_LAT must be at least 2");
   end
   if (DATA_W < 4) begin : g_bad_dw
      $error("DATA_W must be at least 4");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (CW > 256) begin : g_bad_cw
      $error("codeword wider than 256 bits");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   // ---------------- swap control ----------------
   ped_swap_ctrl u_swap (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .upd_done    (upd_done),
      .active      (active_bank),
      .pending     (swap_pending)
   );

   // ---------------- write side ----------------
   logic          wr_ok;
   logic [CW-1:0] enc_code;
   logic [CW-1:0] wr_code;

   assign wr_ok = cfg_wr_en && (cfg_wr_bank != active_bank);

   ped_secded_enc #(.DATA_W(DATA_W)) u_enc (
      .din  (cfg_wdata),
      .code (enc_code)
   );

   assign wr_code = enc_code ^ cfg_flip;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_reject <= 1'b0;
      else        cfg_reject <= cfg_wr_en && (cfg_wr_bank == active_bank);
   end

   // ---------------- table storage ----------------
   logic [CW-1:0] bank_q [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      ped_bank #(.DEPTH(DEPTH), .CW(CW)) u_bank (
         .clk   (clk),
         .we    (wr_ok && (cfg_wr_bank == 1'(b))),
         .waddr (cfg_addr),
         .wcode (wr_code),
         .re    (rd_en && (active_bank == 1'(b))),
         .raddr (rd_addr),
         .rcode (bank_q[b])
      );
   end

   // ---------------- read pipeline ----------------
   logic              s1_v;
   logic              s1_bank;
   logic [CW-1:0]     sel_code;
   logic [DATA_W-1:0] dec_data;
   logic              dec_fix;
   logic              dec_fatal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_bank <= 1'b0;
      end else begin
         s1_v    <= rd_en;
         s1_bank <= active_bank;
      end
   end

   assign sel_code = s1_bank ? bank_q[1] : bank_q[0];

   ped_secded_dec #(.DATA_W(DATA_W)) u_dec (
      .code  (sel_code),
      .dout  (dec_data),
      .fixed (dec_fix),
      .fatal (dec_fatal)
   );

   logic              pv [STG];
   logic              ps [STG];
   logic              pf [STG];
   logic [DATA_W-1:0] pd [STG];

   for (genvar g = 0; g < STG; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pv[g] <= 1'b0;
               ps[g] <= 1'b0;
               pf[g] <= 1'b0;
            end else begin
               pv[g] <= s1_v;
               ps[g] <= s1_v && dec_fix;
               pf[g] <= s1_v && dec_fatal;
            end
         end
         always_ff @(posedge clk) pd[g] <= dec_data;
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pv[g] <= 1'b0;
               ps[g] <= 1'b0;
               pf[g] <= 1'b0;
            end else begin
               pv[g] <= pv[g-1];
               ps[g] <= ps[g-1];
               pf[g] <= pf[g-1];
            end
         end
         always_ff @(posedge clk) pd[g] <= pd[g-1];
      end
   end

   assign rd_valid = pv[STG-1];
   assign rd_data  = pd[STG-1];
   assign rd_dbe   = pf[STG-1];

   // ---------------- error status ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sbe_count <= '0;
         dbe_seen  <= 1'b0;
      end else begin
         if (ps[STG-2] && (sbe_count != '1)) sbe_count <= sbe_count + CNT_W'(1);
         if (pf[STG-2]) dbe_seen <= 1'b1;
      end
   end

   // R3
   reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && (cfg_wr_bank == active_bank)) |=> cfg_reject);

   // R9
   dbe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbe_seen |=> dbe_seen);

   // R9
   dbe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_dbe |-> rd_valid);

   // R8
   sbe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_count != $past(sbe_count)) |-> (sbe_count == $past(sbe_count) + CNT_W'(1)));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (!rd_valid && !cfg_reject));

endmodule

// File: tb/tb_ped_dbuf_ctrl.sv
module tb_ped_dbuf_ctrl;

   localparam int CLK_NS = 10;
   localparam int DW     = 32;
   localparam int DEPTH  = 16;
   localparam int LAT    = 3;
   localparam int CNTW   = 2;
   localparam int AW     = $clog2(DEPTH);
   localparam int CW     = DW + ped_pkg::hm_par_bits(DW) + 1;
   localparam int SAT    = (1 << CNTW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic          cfg_wr_bank = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic [CW-1:0] cfg_flip = '0;
   logic          upd_done = 1'b0;
   logic          cfg_reject;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          rd_dbe;
   logic          active_bank;
   logic          swap_pending;
   logic [CNTW-1:0] sbe_count;
   logic          dbe_seen;

   ped_dbuf_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .RD_LAT(LAT), .CNT_W(CNTW)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_bank(cfg_wr_bank), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_flip(cfg_flip), .upd_done(upd_done),
      .cfg_reject(cfg_reject), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_dbe(rd_dbe),
      .active_bank(active_bank), .swap_pending(swap_pending),
      .sbe_count(sbe_count), .dbe_seen(dbe_seen)
   );

   always #(CLK_NS/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   typedef struct {
      logic [DW-1:0] data;
      int            kind;   // 0 clean, 1 single flip, 2 double flip
      int            due;
   } rd_item_t;

   rd_item_t sb_q[$];

   logic [DW-1:0] m_mem  [2][DEPTH];
   int            m_kind [2][DEPTH];
   bit            m_act  = 1'b0;
   bit            m_pend = 1'b0;
   int            exp_sbe = 0;
   bit            exp_dbe = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat_a(input int a);
      return 32'hC0DE_0000 | (32'(a) * 32'h0000_0111);
   endfunction

   function automatic logic [DW-1:0] pat_b(input int a);
      return 32'h3A50_9000 ^ (32'(a) * 32'h0101_0101);
   endfunction

   // configuration write; checks the reject flag (R2 / R3)
   task automatic cfg_wr(input bit bank, input int a, input logic [DW-1:0] d, input logic [CW-1:0] fl);
      bit to_active;
      to_active = (bank == m_act);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_bank = bank; cfg_addr = AW'(a); cfg_wdata = d; cfg_flip = fl;
      @(negedge clk);
      if (to_active) check(cfg_reject == 1'b1, "R3 reject flag", 64'(cfg_reject), 64'd1);
      else           check(cfg_reject == 1'b0, "R2 no reject", 64'(cfg_reject), 64'd0);
      cfg_wr_en = 1'b0; cfg_flip = '0;
      if (!to_active) begin
         m_mem[bank][a]  = d;
         m_kind[bank][a] = ($countones(fl) >= 2) ? 2 : $countones(fl);
      end
   endtask

   task automatic done_pulse();
      @(negedge clk);
      upd_done = 1'b1;
      @(negedge clk);
      upd_done = 1'b0;
      m_pend = 1'b1;
      check(swap_pending == 1'b1, "R4 pending set", 64'(swap_pending), 64'd1);
      check(active_bank == m_act, "R4 no early swap", 64'(active_bank), 64'(m_act));
   endtask

   task automatic frame(input bit with_done, input bit with_read, input int ra);
      @(negedge clk);
      frame_start = 1'b1;
      upd_done = with_done;
      if (with_read) begin
         rd_en = 1'b1; rd_addr = AW'(ra);
         sb_q.push_back('{m_mem[m_act][ra], m_kind[m_act][ra], cyc + 1 + LAT});
      end
      @(negedge clk);
      frame_start = 1'b0; upd_done = 1'b0; rd_en = 1'b0;
      if (m_pend) begin
         m_act = ~m_act;
         m_pend = 1'b0;
      end else if (with_done) begin
         m_pend = 1'b1;
      end
      check(active_bank == m_act, "R5 active after frame", 64'(active_bank), 64'(m_act));
      check(swap_pending == m_pend, "R5 pending after frame", 64'(swap_pending), 64'(m_pend));
   endtask

   // back-to-back reads of the active table (R6)
   task automatic rd_list(input int addrs[$]);
      foreach (addrs[i]) begin
         @(negedge clk);
         rd_en = 1'b1; rd_addr = AW'(addrs[i]);
         sb_q.push_back('{m_mem[m_act][addrs[i]], m_kind[m_act][addrs[i]], cyc + 1 + LAT});
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 40 && sb_q.size() != 0; k++) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R6 unexpected rd_valid", 64'd1, 64'd0);
            end else begin
               rd_item_t it;
               it = sb_q.pop_front();
               check(cyc == it.due, "R6 read latency", 64'(cyc), 64'(it.due));
               if (it.kind != 2)
                  check(rd_data == it.data, "R6/R8 read data", 64'(rd_data), 64'(it.data));
               check(rd_dbe == (it.kind == 2), "R9/R10 rd_dbe", 64'(rd_dbe), 64'(it.kind == 2));
               if (it.kind == 1 && exp_sbe < SAT) exp_sbe++;
               if (it.kind == 2) exp_dbe = 1'b1;
               check(sbe_count == CNTW'(exp_sbe), "R8/R10 sbe_count", 64'(sbe_count), 64'(exp_sbe));
               check(dbe_seen == exp_dbe, "R9 dbe_seen", 64'(dbe_seen), 64'(exp_dbe));
            end
         end else if (sb_q.size() != 0 && sb_q[0].due < cyc) begin
            check(1'b0, "R6 missing result", 64'(cyc), 64'(sb_q[0].due));
            void'(sb_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int all_addr[$];
      for (int a = 0; a < DEPTH; a++) all_addr.push_back(a);
      for (int b = 0; b < 2; b++)
         for (int a = 0; a < DEPTH; a++) begin
            m_mem[b][a] = '0; m_kind[b][a] = 0;
         end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(active_bank == 1'b0, "R1 active_bank", 64'(active_bank), 64'd0);
      check(swap_pending == 1'b0, "R1 swap_pending", 64'(swap_pending), 64'd0);
      check(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
      check(rd_dbe == 1'b0, "R1 rd_dbe", 64'(rd_dbe), 64'd0);
      check(cfg_reject == 1'b0, "R1 cfg_reject", 64'(cfg_reject), 64'd0);
      check(sbe_count == '0, "R1 sbe_count", 64'(sbe_count), 64'd0);
      check(dbe_seen == 1'b0, "R1 dbe_seen", 64'(dbe_seen), 64'd0);

      // R2: fill shadow table 1; R3: write to active table 0 is dropped
      for (int a = 0; a < DEPTH; a++) cfg_wr(1'b1, a, pat_a(a), '0);
      cfg_wr(1'b0, 7, 32'hDEAD_BEEF, '0);
      // R4: request swap, no swap without frame_start
      done_pulse();
      repeat (3) @(negedge clk);
      check(active_bank == 1'b0, "R4 still old table", 64'(active_bank), 64'd0);
      check(swap_pending == 1'b1, "R4 still pending", 64'(swap_pending), 64'd1);
      frame(1'b0, 1'b0, 0);
      // R6/R10: back-to-back reads of table 1
      rd_list(all_addr);
      drain();

      // R2: fill table 0, R3: attempt on active table 1 addr 2
      for (int a = 0; a < DEPTH; a++) cfg_wr(1'b0, a, pat_b(a), '0);
      cfg_wr(1'b1, 2, 32'h0BAD_0BAD, '0);
      rd_list('{2, 0, 1, 3});
      drain();
      // R5: frame with nothing pending changes nothing
      frame(1'b0, 1'b0, 0);
      // R5: upd_done coincident with frame_start, nothing pending: swap deferred
      frame(1'b1, 1'b0, 0);
      check(active_bank == 1'b1, "R5 deferred swap", 64'(active_bank), 64'd1);
      // R7: read on the swap edge returns the old table
      frame(1'b0, 1'b1, 5);
      rd_list(all_addr);
      drain();

      // R8/R9: damaged words in shadow table 1 (active is 0)
      cfg_wr(1'b1, 3, pat_a(3), CW'(1) << 7);
      cfg_wr(1'b1, 4, pat_a(4), (CW'(1) << 2) | (CW'(1) << 20));
      cfg_wr(1'b1, 5, pat_a(5), CW'(1));
      cfg_wr(1'b1, 6, pat_a(6), CW'(1) << (CW - 1));
      cfg_wr(1'b1, 9, pat_a(9), (CW'(1) << 11) | CW'(1));
      done_pulse();
      frame(1'b0, 1'b0, 0);
      rd_list('{0, 3, 5, 6, 3, 5});
      drain();
      rd_list('{4, 1, 9, 2});
      drain();
      repeat (2) @(negedge clk);
      check(dbe_seen == 1'b1, "R9 sticky dbe_seen", 64'(dbe_seen), 64'd1);
      check(sbe_count == CNTW'(SAT), "R8 saturated count", 64'(sbe_count), 64'(SAT));
      check(sb_q.size() == 0, "R6 all results seen", 64'(sb_q.size()), 64'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule